// File: doc/BRIEF.md
# Bidirectional Port with Per-Bit Open-Drain Control

This block is an eight-pin general-purpose I/O port for a small controller. Software programs three registers over a simple bus: an output latch, a direction mask and an open-drain mask. From these the block produces an output-enable and an output value for every pad. A data read returns, for each bit, either the latch or the synchronized pin level, depending on how that bit is configured.

Push-pull bits drive the latch value. Open-drain bits can only pull low or release the pin. Input bits never drive. Three conditions override all configured drive and float every pin:

- a clock-fault reset, which also clears the registers;
- a global output-enable held low;
- a stop request, when stop tri-stating is selected.

Top module: `gpio_port`

## Requirements
- R1: After the asynchronous reset, all three registers read 0 and every pad output-enable is 0.
- R2: A write strobe with address 0 (latch), 1 (direction) or 2 (open-drain) loads wdata into that register on the next rising clock edge. Reads of addresses 1 and 2 return the stored value.
- R3: A bit whose direction bit is 0 never has its pad output-enable set, whatever its open-drain and latch bits are.
- R4: A bit with direction 1 and open-drain 0 has output-enable 1, and its pad output equals its latch bit.
- R5: A bit with direction 1 and open-drain 1 has output-enable 1 and output 0 when its latch is 0. It has output-enable 0 when its latch is 1.
- R6: A read of address 0 returns the latch bit for bits with direction 1 and open-drain 0. For every other bit it returns the synchronized pin level.
- R7: A pin change appears in address-0 read data after exactly two rising clock edges.
- R8: While the clock-fault reset input is high, all output-enables are 0. At the next edge, all three registers are cleared, and this overrides a write in the same cycle.
- R9: While the global output-enable input is low, all output-enables are 0, and the register contents are kept.
- R10: With both the stop and stop-tristate inputs high, all output-enables are 0. The stop input alone has no effect on the pads.
- R11: Address 3 reads as 0, and a write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkfail_rst | input | 1 | Clock-fault reset: floats pins, clears registers |
| glb_oe | input | 1 | Global output enable, active high |
| stop | input | 1 | Stop-mode request |
| stop_tri | input | 1 | Selects tri-stating of the pads during stop |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for addr |
| pad_in | input | WIDTH | Pin levels from the pads |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_out | output | WIDTH | Per-pin output value |

## Verification
The hardest case to reach is a read where every bit is in a different mode at once. In that read, latch, pin and open-drain behaviour all mix within one byte, so a wrongly selected mux leg shows up only on some bits.

The bench gets there by encoding a bit's index as its mode (direction, open-drain, latch). It then rotates that pattern through all eight positions against several pin patterns. Every bit sees every mode, and the expected read and drive words are computed arithmetically.

A second hard case is a clock-fault reset that coincides with a write. The bench asserts both in the same cycle to show that the clear wins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NREG   = 3;
  typedef enum logic [ADDR_W-1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_ODE   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  ode_q
);
  logic [WIDTH-1:0] reg_q [NREG];
  logic [WIDTH-1:0] reg_d [NREG];
  logic [NREG-1:0]  reg_en;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // write enable decoded from address; clear takes priority
    always_comb begin
      reg_en[g] = clr | (wr_en & (addr == ADDR_W'(g)));
      reg_d[g]  = clr ? '0 : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= '0;
      end else if (reg_en[g]) begin
        reg_q[g] <= reg_d[g];
      end
    end
  end

  assign latch_q = reg_q[int'(SEL_LATCH)];
  assign dir_q   = reg_q[int'(SEL_DIR)];
  assign ode_q   = reg_q[int'(SEL_ODE)];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] ode_q,
  input  logic             force_off,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic drive_en;
    logic drive_val;

    always_comb begin
      drive_en  = 1'b0;
      drive_val = latch_q[b];
      if (dir_q[b]) begin
        if (ode_q[b]) begin
          // open-drain: only pull low
          drive_en  = ~latch_q[b];
          drive_val = 1'b0;
        end else begin
          drive_en  = 1'b1;
          drive_val = latch_q[b];
        end
      end
    end

    assign pad_oe[b]  = drive_en & ~force_off;
    assign pad_out[b] = drive_val;
  end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  latch_q,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  ode_q,
  input  logic [WIDTH-1:0]  pin_s,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] data_view;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign data_view[b] = (dir_q[b] & ~ode_q[b]) ? latch_q[b] : pin_s[b];
  end

  always_comb begin
    unique case (reg_sel_e'(addr))
      SEL_LATCH: rdata = data_view;
      SEL_DIR:   rdata = dir_q;
      SEL_ODE:   rdata = ode_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkfail_rst,
  input  logic              glb_oe,
  input  logic              stop,
  input  logic              stop_tri,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out
);
  logic [WIDTH-1:0] reg_latch;
  logic [WIDTH-1:0] reg_dir;
  logic [WIDTH-1:0] reg_ode;
  logic [WIDTH-1:0] pin_s;
  logic             force_off;

  assign force_off = clkfail_rst | ~glb_oe | (stop & stop_tri);

  gpio_regs #(.WIDTH(WIDTH)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clkfail_rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .latch_q (reg_latch),
    .dir_q   (reg_dir),
    .ode_q   (reg_ode)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_s)
  );

  gpio_drive #(.WIDTH(WIDTH)) i_drive (
    .latch_q   (reg_latch),
    .dir_q     (reg_dir),
    .ode_q     (reg_ode),
    .force_off (force_off),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
  );

  gpio_rdmux #(.WIDTH(WIDTH)) i_rdmux (
    .addr    (addr),
    .latch_q (reg_latch),
    .dir_q   (reg_dir),
    .ode_q   (reg_ode),
    .pin_s   (pin_s),
    .rdata   (rdata)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clkfail_rst,
  input logic              glb_oe,
  input logic              stop,
  input logic              stop_tri,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  wdata,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  latch_q,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  ode_q
);
  p_input_never_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);

  p_od_never_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ode_q & pad_out) == '0);

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(SEL_DIR) && !clkfail_rst) |=> dir_q == $past(wdata));

  p_fault_floats_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clkfail_rst |-> pad_oe == '0);

  p_fault_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clkfail_rst |=> (latch_q == '0 && dir_q == '0 && ode_q == '0));

  p_goe_floats_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_oe |-> pad_oe == '0);

  p_goe_keeps_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_oe && !wr_en && !clkfail_rst) |=> ($stable(dir_q) && $stable(ode_q) && $stable(latch_q)));

  p_stop_floats_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && stop_tri) |-> pad_oe == '0);

  p_hole_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(SEL_NONE) && !clkfail_rst) |=> ($stable(dir_q) && $stable(ode_q) && $stable(latch_q)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clkfail_rst (clkfail_rst),
  .glb_oe      (glb_oe),
  .stop        (stop),
  .stop_tri    (stop_tri),
  .wr_en       (wr_en),
  .addr        (addr),
  .wdata       (wdata),
  .pad_oe      (pad_oe),
  .pad_out     (pad_out),
  .latch_q     (reg_latch),
  .dir_q       (reg_dir),
  .ode_q       (reg_ode)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n, clkfail_rst, glb_oe, stop, stop_tri, wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, pad_in, pad_oe, pad_out;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .clkfail_rst(clkfail_rst), .glb_oe(glb_oe),
    .stop(stop), .stop_tri(stop_tri), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // settle pin into synchronizer: two rising edges
  task automatic set_pins(input logic [7:0] p);
    @(negedge clk);
    pad_in = p;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; clkfail_rst = 1'b0; glb_oe = 1'b1; stop = 1'b0; stop_tri = 1'b0;
    wr_en = 1'b0; addr = 2'd0; wdata = 8'h00; pad_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", pad_oe, 8'h00);
    rd(2'd1, r); check("R1 dir", r, 8'h00);
    rd(2'd2, r); check("R1 ode", r, 8'h00);
    rd(2'd0, r); check("R1 data", r, 8'h00);

    // R2 write/readback
    wr(2'd1, 8'h5A); rd(2'd1, r); check("R2 dir", r, 8'h5A);
    wr(2'd2, 8'hC3); rd(2'd2, r); check("R2 ode", r, 8'hC3);

    // R11 hole address
    wr(2'd3, 8'hFF);
    rd(2'd3, r); check("R11 read", r, 8'h00);
    rd(2'd1, r); check("R11 dir kept", r, 8'h5A);
    rd(2'd2, r); check("R11 ode kept", r, 8'hC3);

    // R3-R6 mode sweep: bit i gets mode (i+rot)%8 = {dir,ode,latch}
    for (int rot = 0; rot < 8; rot++) begin
      logic [7:0] d, o, l, pp, eoe;
      for (int b = 0; b < 8; b++) begin
        int m;
        m = (b + rot) % 8;
        d[b] = m[2]; o[b] = m[1]; l[b] = m[0];
      end
      wr(2'd0, l); wr(2'd1, d); wr(2'd2, o);
      pp  = d & ~o;
      eoe = d & (~o | ~l);
      check("R3/R4/R5 oe", pad_oe, eoe);
      check("R4 push-pull out", pad_out & pp, l & pp);
      check("R5 open-drain out", pad_out & d & o & ~l, 8'h00);
      check("R3 input never driven", pad_oe & ~d, 8'h00);
      for (int p = 0; p < 4; p++) begin
        logic [7:0] pin;
        pin = 8'(p * 8'h55 + rot * 8'h11);
        set_pins(pin);
        rd(2'd0, r);
        check("R6 data read", r, (pp & l) | (~pp & pin));
      end
    end

    // R7 latency: all inputs
    wr(2'd1, 8'h00);
    set_pins(8'h00);
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk); rd(2'd0, r); check("R7 after one edge", r, 8'h00);
    @(negedge clk); rd(2'd0, r); check("R7 after two edges", r, 8'h3C);

    // R10 stop
    wr(2'd0, 8'hA5); wr(2'd1, 8'hFF); wr(2'd2, 8'h00);
    stop = 1'b1; #1;
    check("R10 stop alone oe", pad_oe, 8'hFF);
    check("R10 stop alone out", pad_out, 8'hA5);
    stop_tri = 1'b1; #1;
    check("R10 stop tri oe", pad_oe, 8'h00);
    stop = 1'b0; #1;
    check("R10 release", pad_oe, 8'hFF);
    stop_tri = 1'b0;

    // R9 global output enable
    @(negedge clk); glb_oe = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 oe off", pad_oe, 8'h00);
    rd(2'd1, r); check("R9 dir kept", r, 8'hFF);
    glb_oe = 1'b1; #1;
    check("R9 restored", pad_oe, 8'hFF);

    // R8 clock-fault reset coincident with a write
    wr(2'd2, 8'h0F);
    @(negedge clk);
    clkfail_rst = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 8'hEE; #1;
    check("R8 oe during fault", pad_oe, 8'h00);
    @(negedge clk);
    clkfail_rst = 1'b0; wr_en = 1'b0;
    rd(2'd1, r); check("R8 dir cleared", r, 8'h00);
    rd(2'd2, r); check("R8 ode cleared", r, 8'h00);
    set_pins(8'h96);
    rd(2'd0, r); check("R8 data is pin", r, 8'h96);
    check("R8 oe after", pad_oe, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule